// File: doc/BRIEF.md
# Input Edge Capture and Event Counter Front End

This block watches one asynchronous input pin on behalf of a 32-bit timer. It brings the pin into the clock domain through a short synchronizer and turns each level change into a one-clock rising or falling pulse. The pulse then does one of two jobs.

In timer mode the timer advances on every clock, and a selected edge copies the timer's current count into a capture register. The capture can also raise a sticky interrupt flag. In counter mode the selected pin edges become the timer's increment requests, and the capture path is switched off whatever the capture control bits say.

Software reaches four small registers through a plain write-strobe port with a combinational read path. That port has no valid/ready handshake: a write takes effect at the clock edge where `reg_wr` is high, and nothing can stall it. The count output and the interrupt output are plain level or pulse pins, and the timer itself lies outside the block.

Top module: `capin_unit`

## Requirements
- R1: After reset the capture value, capture control and count mode all read 0, and the interrupt flag is 0.
- R2: If the pin changes level just before clock edge k, the capture register holds the `tmr_value` present at edge k+2, and the interrupt flag, when enabled, is set at that same edge.
- R3: In timer mode, capture control bit 0 enables capture on a rising pin edge and bit 1 enables capture on a falling pin edge. With both bits set, either edge captures; with neither set, no edge captures.
- R4: The interrupt flag is set by a capture only when capture control bit 2 is 1. A capture with bit 2 at 0 leaves the flag at 0.
- R5: The interrupt flag stays set until a write to address 3 with data bit 0 equal to 1 clears it. A write of 0 to address 3 leaves the flag unchanged.
- R6: A new capture overwrites the stored capture value. A pin edge that does not capture leaves the stored value unchanged.
- R7: Count mode 00 (timer mode) drives `count_inc` high on every clock.
- R8: The counter modes are 01 (rising edges), 10 (falling edges) and 11 (both edges). In these modes `count_inc` is high for exactly one clock per selected edge, during the cycle between edges k+1 and k+2. A pin edge that is not selected produces no pulse.
- R9: In any counter mode, capture control bits 0 to 2 have no effect. Pin edges then cause no capture and do not set the interrupt flag.
- R10: The register map is: address 0 holds capture control in bits [2:0]; address 1 holds count mode in bits [1:0]; address 2 holds the capture value and is read-only, so writes to it are ignored; address 3 holds the interrupt flag in bit 0. Reads return the value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_async | input | 1 | Asynchronous input pin, used as capture trigger or count source |
| tmr_value | input | TMR_W | Current timer count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | TMR_W | Combinational read data for `reg_addr` |
| count_inc | output | 1 | Increment request to the timer |
| cap_irq | output | 1 | Sticky capture interrupt flag |

## Verification
The assertions assume that the pin is held low through reset, so that the synchronizer does not report a spurious edge on its first cycle. They also assume that the pin holds each level for at least three clocks; edges closer together than that could merge, and the single-pulse checks would no longer describe the stimulus. The bench changes the pin only at falling clock edges and keeps it steady for more than four cycles around each event. It parks the pin at its starting level while the block is in timer mode with capture disabled, so that the parking step cannot capture, count or set the flag.

// File: rtl/capin_pkg.sv
package capin_pkg;

  typedef enum logic [1:0] {
    CNT_TIMER = 2'b00,
    CNT_RISE  = 2'b01,
    CNT_FALL  = 2'b10,
    CNT_BOTH  = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic irq_en;
    logic on_fall;
    logic on_rise;
  } cap_ctl_t;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_CAP  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

endpackage

// File: rtl/capin_sync.sv
module capin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;

  // R8: every detected edge is a single-cycle pulse
  a_r8_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r8_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
  a_r8_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/capin_event.sv
module capin_event
  import capin_pkg::*;
(
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      on_rise_i,
  input  logic      on_fall_i,
  input  cnt_mode_e mode_i,
  output logic      cap_fire_o,
  output logic      count_inc_o
);
  logic timer_mode;
  logic edge_sel;

  always_comb begin
    timer_mode = (mode_i == CNT_TIMER);
    edge_sel   = (mode_i[0] & rise_i) | (mode_i[1] & fall_i);
    // capture is allowed only while the pin is not the count source
    cap_fire_o  = timer_mode & ((on_rise_i & rise_i) | (on_fall_i & fall_i));
    count_inc_o = timer_mode | edge_sel;
  end
endmodule

// File: rtl/capin_regs.sv
module capin_regs
  import capin_pkg::*;
#(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [2:0]       wdata,
  output logic [TMR_W-1:0] rdata,
  input  logic             cap_load,
  input  logic [TMR_W-1:0] cap_in,
  input  logic             flag_set,
  output cap_ctl_t         ctl_o,
  output cnt_mode_e        mode_o,
  output logic [TMR_W-1:0] cap_o,
  output logic             flag_o
);
  logic flag_clr;
  assign flag_clr = wr_en && (addr == ADDR_FLAG) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_o  <= '0;
      mode_o <= CNT_TIMER;
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_CTL)  ctl_o  <= cap_ctl_t'(wdata);
      if (wr_en && addr == ADDR_MODE) mode_o <= cnt_mode_e'(wdata[1:0]);
      if (cap_load) cap_o <= cap_in;
      // a capture in the clearing cycle wins
      if (flag_set)      flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTL:  rdata[2:0] = ctl_o;
      ADDR_MODE: rdata[1:0] = mode_o;
      ADDR_CAP:  rdata      = cap_o;
      ADDR_FLAG: rdata[0]   = flag_o;
      default:   rdata      = '0;
    endcase
  end

  // R5: flag holds until cleared by a write of 1
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr |=> flag_o);
  // R10: capture register changes only on a capture load
  a_r10_cap_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_load |=> $stable(cap_o));
endmodule

// File: rtl/capin_unit.sv
module capin_unit
  import capin_pkg::*;
#(
  parameter int TMR_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_async,
  input  logic [TMR_W-1:0] tmr_value,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [2:0]       reg_wdata,
  output logic [TMR_W-1:0] reg_rdata,
  output logic             count_inc,
  output logic             cap_irq
);
  logic             rise, fall, cap_fire;
  cap_ctl_t         ctl;
  cnt_mode_e        mode;
  logic [TMR_W-1:0] cap_q;

  capin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
    .rise_o(rise), .fall_o(fall)
  );

  capin_event u_event (
    .rise_i(rise), .fall_i(fall),
    .on_rise_i(ctl.on_rise), .on_fall_i(ctl.on_fall), .mode_i(mode),
    .cap_fire_o(cap_fire), .count_inc_o(count_inc)
  );

  capin_regs #(.TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .cap_load(cap_fire), .cap_in(tmr_value), .flag_set(cap_fire & ctl.irq_en),
    .ctl_o(ctl), .mode_o(mode), .cap_o(cap_q), .flag_o(cap_irq)
  );

  // R2: a capture stores the timer value seen at its edge
  a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_q == $past(tmr_value));
  // R9: no capture while counting pin edges
  a_r9_counter_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mode != CNT_TIMER |=> $stable(cap_q));
  // R7: timer mode increments every clock
  a_r7_timer_inc: assert property (@(posedge clk) disable iff (!rst_n)
    mode == CNT_TIMER |-> count_inc);
  // R8: counter mode increments only on a detected edge
  a_r8_count_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != CNT_TIMER && count_inc) |-> (rise || fall));
endmodule

// File: tb/tb_capin_unit.sv
module tb_capin_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_async = 1'b0;
  logic [31:0] tmr_value = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [2:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        count_inc, cap_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_cap = '0;

  always #10 clk = ~clk;

  capin_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .tmr_value(tmr_value),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count_inc(count_inc), .cap_irq(cap_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic trial(input int idx, input logic [2:0] ctl, input logic [1:0] mode, input bit up);
    logic [31:0] v, val_c;
    int incs;
    logic inc_mid;
    bit timer, cap, hit;
    wr(2'd0, 3'd0); wr(2'd1, 3'd0);
    @(negedge clk); pin_async = ~up;
    repeat (4) @(negedge clk);
    wr(2'd1, {1'b0, mode}); wr(2'd0, ctl); wr(2'd3, 3'd1);
    @(negedge clk); pin_async = up; tmr_value = 32'h1000_0000 + idx * 16;
    incs = 0; inc_mid = 1'b0; val_c = '0;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      if (count_inc) incs++;
      if (c == 2) inc_mid = count_inc;
      tmr_value = 32'h1000_0000 + idx * 16 + c;
      if (c == 2) val_c = tmr_value;
    end
    timer = (mode == 2'b00);
    cap   = timer && (up ? ctl[0] : ctl[1]);
    hit   = up ? mode[0] : mode[1];
    if (cap) exp_cap = val_c;
    rd(2'd2, v);
    check(v == exp_cap, "R2 R3 R6 R9 capture value", v, exp_cap);
    rd(2'd3, v);
    check(v == {31'd0, cap && ctl[2]}, "R4 R9 interrupt flag", v, {31'd0, cap && ctl[2]});
    check(cap_irq == (cap && ctl[2]), "R4 irq pin", cap_irq, cap && ctl[2]);
    if (timer)
      check(incs == 5, "R7 timer mode count_inc", incs, 5);
    else begin
      check(incs == (hit ? 1 : 0), "R8 counter pulses", incs, hit ? 1 : 0);
      check(inc_mid == hit, "R8 pulse cycle", inc_mid, hit);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check(v == 0, "R1 ctl reset", v, 0);
    rd(2'd1, v); check(v == 0, "R1 mode reset", v, 0);
    rd(2'd2, v); check(v == 0, "R1 capture reset", v, 0);
    rd(2'd3, v); check(v == 0, "R1 flag reset", v, 0);
    // R10 readback and read-only capture
    wr(2'd0, 3'd5); rd(2'd0, v); check(v == 5, "R10 ctl readback", v, 5);
    wr(2'd1, 3'd2); rd(2'd1, v); check(v == 2, "R10 mode readback", v, 2);
    wr(2'd1, 3'd0); wr(2'd0, 3'd0);
    wr(2'd2, 3'd7); rd(2'd2, v); check(v == 0, "R10 write to capture ignored", v, 0);
    // near-exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 8; c++)
        for (int d = 0; d < 2; d++)
          trial(m * 16 + c * 2 + d, 3'(c), 2'(m), d[0]);
    // R5 stickiness and clearing
    trial(200, 3'b101, 2'b00, 1'b1);
    repeat (6) @(negedge clk);
    check(cap_irq == 1'b1, "R5 flag stays set", cap_irq, 1);
    wr(2'd3, 3'd0); #1 check(cap_irq == 1'b1, "R5 write 0 keeps flag", cap_irq, 1);
    wr(2'd3, 3'd1); #1 check(cap_irq == 1'b0, "R5 write 1 clears flag", cap_irq, 0);
    // R6 back-to-back overwrite
    trial(300, 3'b011, 2'b00, 1'b1);
    trial(301, 3'b011, 2'b00, 1'b0);
    rd(2'd2, v); check(v == exp_cap, "R6 latest capture kept", v, exp_cap);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule